// File: doc/BRIEF.md
# Opcode Prefetch Queue and Byte-Bus Arbiter

This block is the bus side of a small processor whose external bus carries one byte at a time. It holds a short queue of opcode bytes fetched ahead of use, and it shares the single bus between those opcode fetches and the memory or I/O data moves that the execution side asks for. The execution side takes opcode bytes from the head of the queue. It starts byte or word data moves with a one-clock request and receives a one-clock completion pulse. It can also redirect fetching to a new address when a branch is taken.

Each bus cycle lasts four clocks. Data moves always win a free bus slot over opcode fetches. A word costs two back-to-back bus cycles, so an execution side that is busy with data quickly drains the queue and then has to wait. A saturating counter reports how many clocks the execution side spent waiting on an empty queue, so that a loop's bus-bound timing can be checked against a model.

Top module: `prefetch_biu`

## Requirements
- R1: The queue holds at most 4 opcode bytes, and `q_level` never exceeds 4. Once the queue is full and no data move is pending, the bus goes idle.
- R2: Every bus cycle moves one byte and lasts exactly 4 clocks. `bus_strobe` is high in its first clock and `bus_active` is high in all four. The read byte is sampled in the fourth clock.
- R3: A word move is carried out as two back-to-back bus cycles, first at `xfer_addr` and then at `xfer_addr`+1. Read data is returned as {second byte, first byte}. `xfer_done` is high in the 8th clock after the first cycle's strobe clock. For a byte move it is high in the 4th clock after that strobe clock, and `xfer_rdata` is {8'h00, byte}.
- R4: A data request that is pending when the bus becomes free takes the next bus cycle ahead of any opcode fetch. A request present at the same clock edge counts as pending.
- R5: `stall_count` increases by one for each clock in which `pop_req` is high, `q_level` is 0 and `branch` is low. In any other clock it holds its value. It saturates at its maximum.
- R6: A clock with `branch` high empties the queue. Opcode fetching then continues from `branch_addr` upward, one address per byte.
- R7: A fetch cycle already under way when `branch` is seen runs its full 4 clocks on the bus. Its byte is dropped, and the first fetch from the new address begins in the following clock.
- R8: Opcode bytes leave the queue in address order. The fetch address advances by one for each byte written into the queue. After reset, fetching starts at address 0.
- R9: A pop and a fetch completion in the same clock leave `q_level` unchanged. When the new level is below 4, the next fetch cycle starts in the following clock.
- R10: On a write, `bus_wr` is 1 and `bus_wdata` carries the low byte of `xfer_wdata` in the first cycle and the high byte in the second. `bus_io` is 1 for I/O moves and 0 for memory moves and opcode fetches.
- R11: During reset, `q_level`, `bus_active`, `bus_strobe`, `xfer_done` and `stall_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_req | input | 1 | Execution side takes the head byte when the queue is not empty |
| op_byte | output | 8 | Byte at the queue head |
| q_level | output | 3 | Number of bytes in the queue |
| branch | input | 1 | Taken branch: flush the queue and refetch |
| branch_addr | input | ADDR_W | New fetch address |
| xfer_go | input | 1 | One-clock data move request |
| xfer_wr | input | 1 | 1 for a write, 0 for a read |
| xfer_io | input | 1 | 1 for I/O space, 0 for memory |
| xfer_word | input | 1 | 1 for a 16-bit move, 0 for a byte |
| xfer_addr | input | ADDR_W | Data address |
| xfer_wdata | input | 16 | Write data |
| xfer_done | output | 1 | One-clock completion pulse |
| xfer_rdata | output | 16 | Read data, valid with `xfer_done` |
| bus_active | output | 1 | Bus cycle in progress |
| bus_strobe | output | 1 | First clock of a bus cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_io | output | 1 | I/O space select |
| bus_wr | output | 1 | Write cycle |
| bus_wdata | output | 8 | Byte driven on a write |
| bus_rdata | input | 8 | Byte returned on a read, sampled in the 4th clock |
| stall_count | output | STALL_W | Clocks spent waiting on an empty queue |

## Verification
Two pairs of events are made to land on the same clock edge. In the first, a queued byte is popped at the very edge where a fetch cycle delivers its byte. The bench times the pop by counting clocks from a single pop that left three bytes, and it expects the level to stay at 3 with a fresh strobe in the next clock. In the second, a branch arrives in the second clock of a fetch cycle. The bench expects that cycle to keep the bus for its remaining clocks, the queue to read empty at once, the next strobe to carry the target address exactly two clocks later, and every later popped byte to match the scoreboard's target-based sequence, so a stale byte shows up as a mismatch.

// File: rtl/prefetch_biu.sv
module prefetch_biu #(
  parameter int ADDR_W  = 20,
  parameter int DEPTH   = 4,
  parameter int STALL_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pop_req,
  output logic [7:0]                  op_byte,
  output logic [$clog2(DEPTH+1)-1:0]  q_level,
  input  logic                        branch,
  input  logic [ADDR_W-1:0]           branch_addr,
  input  logic                        xfer_go,
  input  logic                        xfer_wr,
  input  logic                        xfer_io,
  input  logic                        xfer_word,
  input  logic [ADDR_W-1:0]           xfer_addr,
  input  logic [15:0]                 xfer_wdata,
  output logic                        xfer_done,
  output logic [15:0]                 xfer_rdata,
  output logic                        bus_active,
  output logic                        bus_strobe,
  output logic [ADDR_W-1:0]           bus_addr,
  output logic                        bus_io,
  output logic                        bus_wr,
  output logic [7:0]                  bus_wdata,
  input  logic [7:0]                  bus_rdata,
  output logic [STALL_W-1:0]          stall_count
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [7:0]        q_mem [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     q_cnt, cnt_nx;
  logic [ADDR_W-1:0] pf_addr, pf_addr_nx;

  logic              busy;
  logic [1:0]        phase;
  logic              cur_data, cur_word, cur_hi, cur_drop;
  logic [7:0]        wdata_hi;

  logic              pend, p_wr, p_io, p_word;
  logic [ADDR_W-1:0] p_addr;
  logic [15:0]       p_wdata;

  logic              e_wr, e_io, e_word;
  logic [ADDR_W-1:0] e_addr;
  logic [15:0]       e_wdata;

  logic at_end, slot, pf_end, data_end, second, waiting;
  logic push, pop, start_hi, start_data, start_pf, start_any;

  assign at_end   = busy && (phase == 2'd3);
  assign slot     = !busy || at_end;
  assign pf_end   = at_end && !cur_data;
  assign data_end = at_end && cur_data;
  assign second   = data_end && cur_word && !cur_hi;
  assign waiting  = pend || xfer_go;

  assign push = pf_end && !cur_drop && !branch;
  assign pop  = pop_req && (q_cnt != '0) && !branch;

  assign cnt_nx     = branch ? '0 : q_cnt + CW'(push) - CW'(pop);
  assign pf_addr_nx = branch ? branch_addr : (push ? pf_addr + 1'b1 : pf_addr);

  assign start_hi   = slot && second;
  assign start_data = slot && !second && waiting;
  assign start_pf   = slot && !second && !waiting && (cnt_nx < FULL);
  assign start_any  = start_hi || start_data || start_pf;

  assign e_wr    = pend ? p_wr    : xfer_wr;
  assign e_io    = pend ? p_io    : xfer_io;
  assign e_word  = pend ? p_word  : xfer_word;
  assign e_addr  = pend ? p_addr  : xfer_addr;
  assign e_wdata = pend ? p_wdata : xfer_wdata;

  assign op_byte    = q_mem[rd_ptr];
  assign q_level    = q_cnt;
  assign bus_active = busy;
  assign bus_strobe = busy && (phase == 2'd0);

  always_ff @(posedge clk) begin
    if (push) q_mem[wr_ptr] <= bus_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      q_cnt   <= '0;
      pf_addr <= '0;
    end else begin
      q_cnt   <= cnt_nx;
      pf_addr <= pf_addr_nx;
      if (branch) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
      end else begin
        if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_wr    <= 1'b0;
      p_io    <= 1'b0;
      p_word  <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
    end else begin
      if (start_data)   pend <= 1'b0;
      else if (xfer_go) pend <= 1'b1;
      if (xfer_go) begin
        p_wr    <= xfer_wr;
        p_io    <= xfer_io;
        p_word  <= xfer_word;
        p_addr  <= xfer_addr;
        p_wdata <= xfer_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= 2'd0;
      cur_data  <= 1'b0;
      cur_word  <= 1'b0;
      cur_hi    <= 1'b0;
      cur_drop  <= 1'b0;
      wdata_hi  <= '0;
      bus_addr  <= '0;
      bus_io    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
    end else begin
      if (start_any) begin
        busy     <= 1'b1;
        phase    <= 2'd0;
        cur_drop <= 1'b0;
      end else begin
        if (at_end) busy <= 1'b0;
        if (busy)   phase <= phase + 2'd1;
        if (branch && busy && !cur_data) cur_drop <= 1'b1;
      end
      if (start_hi) begin
        cur_hi    <= 1'b1;
        bus_addr  <= bus_addr + 1'b1;
        bus_wdata <= wdata_hi;
      end else if (start_data) begin
        cur_data  <= 1'b1;
        cur_word  <= e_word;
        cur_hi    <= 1'b0;
        bus_addr  <= e_addr;
        bus_io    <= e_io;
        bus_wr    <= e_wr;
        bus_wdata <= e_wdata[7:0];
        wdata_hi  <= e_wdata[15:8];
      end else if (start_pf) begin
        cur_data  <= 1'b0;
        cur_word  <= 1'b0;
        cur_hi    <= 1'b0;
        bus_addr  <= pf_addr_nx;
        bus_io    <= 1'b0;
        bus_wr    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      xfer_done <= data_end && (!cur_word || cur_hi);
      if (data_end) begin
        if (!cur_word)   xfer_rdata <= {8'h00, bus_rdata};
        else if (!cur_hi) xfer_rdata[7:0] <= bus_rdata;
        else              xfer_rdata[15:8] <= bus_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stall_count <= '0;
    else if (pop_req && (q_cnt == '0) && !branch && (stall_count != '1))
      stall_count <= stall_count + 1'b1;
  end

  a_r1_level_max: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= FULL);

  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && !pop && (q_cnt == FULL)));

  a_r2_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> (bus_active && !bus_strobe) ##1 (bus_active && !bus_strobe)
                   ##1 (bus_active && !bus_strobe));

  a_r3_word_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && cur_data && cur_word && !cur_hi) |=> ##3
      (bus_strobe && (bus_addr == $past(bus_addr, 4) + 1'b1)));

  a_r4_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && waiting && !second) |=>
      (bus_strobe && (bus_addr == $past(pend ? p_addr : xfer_addr))));

  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    branch |=> (q_level == '0));

  a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && busy && (phase != 2'd3)) |=> (bus_active && !bus_strobe));

  a_r5_hold_when_fed: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_req && (q_level == '0) && !branch) |=> $stable(stall_count));
endmodule

// File: tb/prefetch_biu_tb.sv
module prefetch_biu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic clk = 0, rst_n = 0;
  logic pop_req = 0, branch = 0;
  logic [AW-1:0] branch_addr = '0;
  logic xfer_go = 0, xfer_wr = 0, xfer_io = 0, xfer_word = 0;
  logic [AW-1:0] xfer_addr = '0;
  logic [15:0] xfer_wdata = '0;
  logic [7:0] op_byte, bus_wdata, bus_rdata;
  logic [2:0] q_level;
  logic xfer_done, bus_active, bus_strobe, bus_io, bus_wr;
  logic [15:0] xfer_rdata, stall_count;
  logic [AW-1:0] bus_addr;

  int checks = 0, failures = 0, strobes = 0, run = 0;
  logic [7:0] exp_q [$];
  logic [15:0] dq [$];
  bit mon_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_biu u_dut (
    .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .op_byte(op_byte), .q_level(q_level),
    .branch(branch), .branch_addr(branch_addr), .xfer_go(xfer_go), .xfer_wr(xfer_wr),
    .xfer_io(xfer_io), .xfer_word(xfer_word), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
    .bus_active(bus_active), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .bus_io(bus_io), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stall_count(stall_count));

  function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] io_b(input logic [AW-1:0] a);
    return ~a[7:0];
  endfunction

  assign bus_rdata = bus_io ? io_b(bus_addr) : mem_b(bus_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) if (mon_on) begin
    if (pop_req && !branch && q_level != 0) begin
      if (exp_q.size() == 0) check(0, "R8 opcode order (queue empty)", op_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(op_byte == e, "R8 opcode byte order", op_byte, e);
      end
    end
    if (xfer_done) begin
      if (dq.size() != 0) begin
        logic [15:0] d;
        d = dq.pop_front();
        check(xfer_rdata == d, "R3 read data", xfer_rdata, d);
      end
    end
    if (bus_strobe) begin
      strobes++;
      if (run > 0) check(run == 4, "R2 cycle length", run, 4);
      run = 1;
    end else if (bus_active) run++;
    else if (run > 0) begin
      check(run == 4, "R2 cycle length", run, 4);
      run = 0;
    end
  end

  task automatic load_exp(input logic [AW-1:0] base);
    exp_q.delete();
    for (int i = 0; i < 64; i++) exp_q.push_back(mem_b(base + AW'(i)));
  endtask

  task automatic do_branch(input logic [AW-1:0] t);
    @(posedge clk); #1;
    branch = 1; branch_addr = t;
    load_exp(t);
    @(posedge clk); #1;
    branch = 0;
  endtask

  task automatic pop_n(input int n);
    int k = 0;
    pop_req = 1;
    while (k < n) begin
      @(negedge clk);
      if (q_level != 0) k++;
      @(posedge clk); #1;
    end
    pop_req = 0;
  endtask

  task automatic do_xfer(input bit word, input bit wr, input bit io,
                         input logic [AW-1:0] a, input logic [15:0] wd);
    logic [7:0] b0, b1;
    b0 = io ? io_b(a) : mem_b(a);
    b1 = io ? io_b(a + 1) : mem_b(a + 1);
    @(posedge clk); #1;
    xfer_go = 1; xfer_wr = wr; xfer_io = io; xfer_word = word;
    xfer_addr = a; xfer_wdata = wd;
    if (!wr) dq.push_back(word ? {b1, b0} : {8'h00, b0});
    @(posedge clk); #1;
    xfer_go = 0;
    do @(negedge clk); while (!bus_strobe);
    check(bus_addr == a, "R4 data cycle before prefetch", bus_addr, a);
    check(bus_io == io && bus_wr == wr, "R10 space and direction", {bus_io, bus_wr}, {io, wr});
    if (wr) check(bus_wdata == wd[7:0], "R10 low byte first", bus_wdata, wd[7:0]);
    if (word) begin
      repeat (4) @(negedge clk);
      check(bus_strobe && bus_addr == a + 1, "R3 second byte cycle", bus_addr, a + 1);
      if (wr) check(bus_wdata == wd[15:8], "R10 high byte second", bus_wdata, wd[15:8]);
    end
    repeat (4) @(negedge clk);
    check(xfer_done == 1, "R3 done timing", xfer_done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0, k;
    load_exp('0);
    repeat (3) @(negedge clk);
    check(q_level == 0 && !bus_active && !bus_strobe && !xfer_done && stall_count == 0,
          "R11 reset state", {q_level, bus_active, xfer_done}, 0);
    @(posedge clk); #1;
    rst_n = 1; mon_on = 1;
    repeat (30) tick();
    @(negedge clk);
    check(q_level == 4, "R1 queue fills to 4", q_level, 4);
    check(!bus_active, "R1 bus idle when full", bus_active, 0);
    check(strobes == 4, "R8 one fetch per byte", strobes, 4);

    s0 = stall_count;
    do_branch(20'h0_1000);
    pop_n(3);
    @(negedge clk);
    check(stall_count - s0 == 10, "R5 stall clocks after flush", stall_count - s0, 10);
    check(stall_count != 0, "R6 refetch after flush", stall_count, 1);

    repeat (30) tick();
    @(negedge clk);
    check(q_level == 4, "R1 refilled", q_level, 4);
    tick();
    s0 = stall_count;
    pop_n(1);
    tick(); tick(); tick();
    pop_req = 1;
    @(negedge clk);
    check(q_level == 3, "R9 level before coincidence", q_level, 3);
    tick();
    pop_req = 0;
    @(negedge clk);
    check(q_level == 3, "R9 push and pop same clock", q_level, 3);
    check(bus_strobe == 1, "R9 next fetch starts", bus_strobe, 1);
    check(stall_count == s0, "R5 no stall while fed", stall_count, s0);

    repeat (30) tick();
    pop_n(1);
    do_branch(20'h2_00F0);
    @(negedge clk);
    check(bus_active && !bus_strobe, "R7 fetch cycle not aborted", bus_active, 1);
    check(q_level == 0, "R6 queue flushed", q_level, 0);
    k = 0;
    do begin @(negedge clk); k++; end while (!bus_strobe && k < 10);
    check(k == 2, "R7 new fetch after old cycle ends", k, 2);
    check(bus_addr == 20'h2_00F0, "R6 fetch from target", bus_addr, 20'h2_00F0);
    tick();
    pop_n(3);

    do_xfer(1, 0, 0, 20'h8_1234, 16'h0);
    do_xfer(0, 0, 1, 20'h0_0060, 16'h0);
    do_xfer(0, 1, 1, 20'h0_0061, 16'h00C3);
    do_xfer(1, 1, 0, 20'h4_4440, 16'hBEEF);
    repeat (12) @(negedge clk);
    check(dq.size() == 0, "R3 all reads completed", dq.size(), 0);
    s0 = stall_count;
    repeat (20) tick();
    check(stall_count == s0, "R5 counter holds without pop", stall_count, s0);
    pop_n(4);

    repeat (10) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule